// File: doc/BRIEF.md
# Dual-Mode Frequency and Period Counter

This block measures how fast a digital input toggles, in one of two ways. In gated mode it opens a window of a fixed number of reference clock cycles and counts the rising edges of the input that arrive inside it. In period mode it waits for one rising edge of the input, then counts reference clock cycles until the next rising edge, so the result is the length of one input period. The conversion from a period count to hertz is left to whatever reads the result.

A two-bit selector picks one of three inputs: an external counter input, a demodulated tone input, or a monitor IF line. The chosen input is resynchronised into the reference clock domain before its edges are detected. When a gated measurement is taken on the IF line, the block also reports a signed offset from the count that the nominal IF frequency would give for the same window.

Each measurement begins with a one-cycle `start` pulse. When it ends, the block raises `done` for one cycle and holds the result and flags on its outputs until the next measurement finishes.

Top module: `freq_meter`

## Requirements
- R1: In gated mode (`recip`=0), `count` is the number of rising edges of the selected input seen during the gate window. For a steady input of period P cycles and a window of G cycles, `count` lies between floor(G/P) and ceil(G/P).
- R2: `gate_sel` sets the window length in reference cycles: 0 gives REF_HZ/100, 1 gives REF_HZ/10, and 2 or 3 give REF_HZ (10 ms, 100 ms and 1 s).
- R3: In period mode (`recip`=1), `count` equals the number of reference cycles from one rising edge of the selected input to the next.
- R4: `src_sel` picks the input: 0 picks `sig_ext`, 1 picks `sig_tone`, 2 picks `sig_if`, and 3 picks `sig_ext`. It must be held steady from a few cycles before `start` until `done`.
- R5: When a gated measurement on the IF source completes, `if_valid` is 1 and `if_error` equals `count` minus the nominal count, as a signed value of CW+1 bits. The nominal count is IF_NOM_HZ/100, IF_NOM_HZ/10 or IF_NOM_HZ for gate codes 0, 1 and 2 or 3. For any other completed measurement, `if_valid` is 0 and `if_error` is 0.
- R6: `overflow` is 1 with a result exactly when the CW-bit accumulator wrapped during that measurement.
- R7: `done` is high for exactly one cycle per measurement. `busy` is high from the cycle after an accepted `start` until the cycle in which `done` rises.
- R8: `count`, `overflow`, `if_valid` and `if_error` change only in the cycle in which `done` is high. They are held at all other times, including through a later `start`.
- R9: A `start` pulse that arrives while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `count`, `overflow`, `if_valid` and `if_error` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that starts a measurement |
| recip | input | 1 | 0 selects gated counting, 1 selects period counting |
| src_sel | input | 2 | Input source select |
| gate_sel | input | 2 | Gate window select |
| sig_ext | input | 1 | External counter input |
| sig_tone | input | 1 | Demodulated tone input |
| sig_if | input | 1 | Monitor IF input |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle completion pulse |
| count | output | CW | Edge count or period count |
| overflow | output | 1 | Accumulator wrapped during the last measurement |
| if_valid | output | 1 | `if_error` holds an IF offset |
| if_error | output | CW+1 | Signed offset of an IF count from its nominal count |

## Verification
The bench builds the block with REF_HZ=1000, IF_NOM_HZ=200 and CW=10. This makes the three gate windows 10, 100 and 1000 cycles long, so every window code and a range of input periods can be swept in a short run. With these values the nominal IF counts are 2, 20 and 200. An IF period of 5 cycles lands on the nominal count, and shorter or longer periods give positive or negative offsets. A 10-bit accumulator lets a period of 1100 cycles drive the overflow path within a few thousand cycles.

// File: rtl/fm_pkg.sv
package fm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GATE = 2'd1,
        ST_ARM  = 2'd2,
        ST_MEAS = 2'd3
    } fm_state_e;

    localparam logic [1:0] SRC_EXT  = 2'd0;
    localparam logic [1:0] SRC_TONE = 2'd1;
    localparam logic [1:0] SRC_IF   = 2'd2;

endpackage

// File: rtl/fm_input_sync.sv
module fm_input_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       sig_ext,
    input  logic       sig_tone,
    input  logic       sig_if,
    output logic       rise
);
    import fm_pkg::*;

    logic       picked;
    logic [STAGES:0] shr_q;

    always_comb begin
        unique case (src_sel)
            SRC_TONE: picked = sig_tone;
            SRC_IF:   picked = sig_if;
            default:  picked = sig_ext;
        endcase
    end

    // Synchroniser chain plus one extra flop for edge detection.
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shr_q[0] <= 1'b0;
                else        shr_q[0] <= picked;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shr_q[i] <= 1'b0;
                else        shr_q[i] <= shr_q[i-1];
            end
        end
    end

    assign rise = shr_q[STAGES-1] & ~shr_q[STAGES];

endmodule

// File: rtl/fm_gate_table.sv
module fm_gate_table #(
    parameter int REF_HZ    = 1_000_000,
    parameter int IF_NOM_HZ = 700_000,
    parameter int CW        = 24,
    localparam int GW       = $clog2(REF_HZ + 1)
) (
    input  logic [1:0]    gate_sel,
    output logic [GW-1:0] gate_len,
    output logic [CW-1:0] nom_count
);
    localparam logic [GW-1:0] LEN_SHORT = GW'(REF_HZ / 100);
    localparam logic [GW-1:0] LEN_MID   = GW'(REF_HZ / 10);
    localparam logic [GW-1:0] LEN_LONG  = GW'(REF_HZ);
    localparam logic [CW-1:0] NOM_SHORT = CW'(IF_NOM_HZ / 100);
    localparam logic [CW-1:0] NOM_MID   = CW'(IF_NOM_HZ / 10);
    localparam logic [CW-1:0] NOM_LONG  = CW'(IF_NOM_HZ);

    always_comb begin
        unique case (gate_sel)
            2'd0: begin gate_len = LEN_SHORT; nom_count = NOM_SHORT; end
            2'd1: begin gate_len = LEN_MID;   nom_count = NOM_MID;   end
            default: begin gate_len = LEN_LONG; nom_count = NOM_LONG; end
        endcase
    end

endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
    parameter int REF_HZ    = 1_000_000,
    parameter int IF_NOM_HZ = 700_000,
    parameter int CW        = 24,
    parameter int SYNC      = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          recip,
    input  logic [1:0]    src_sel,
    input  logic [1:0]    gate_sel,
    input  logic          sig_ext,
    input  logic          sig_tone,
    input  logic          sig_if,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] count,
    output logic          overflow,
    output logic          if_valid,
    output logic [CW:0]   if_error
);
    import fm_pkg::*;

    localparam int GW = $clog2(REF_HZ + 1);

    typedef struct packed {
        fm_state_e     st;
        logic [GW-1:0] gcnt;
        logic [CW-1:0] acc;
        logic          wrap;
        logic          on_if;
        logic [CW-1:0] nom;
        logic [CW-1:0] res;
        logic          ovf;
        logic          done;
        logic          ifv;
        logic [CW:0]   err;
    } fm_regs_t;

    fm_regs_t r_q, r_d;

    logic          rise;
    logic [GW-1:0] gate_len;
    logic [CW-1:0] nom_count;

    fm_input_sync #(.STAGES(SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .sig_ext  (sig_ext),
        .sig_tone (sig_tone),
        .sig_if   (sig_if),
        .rise     (rise)
    );

    fm_gate_table #(.REF_HZ(REF_HZ), .IF_NOM_HZ(IF_NOM_HZ), .CW(CW)) u_gate (
        .gate_sel  (gate_sel),
        .gate_len  (gate_len),
        .nom_count (nom_count)
    );

    logic [CW:0]   acc_inc;
    logic [CW-1:0] acc_n;
    logic          wrap_n;
    logic          finish;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        acc_inc  = {1'b0, r_q.acc} + {{CW{1'b0}}, 1'b1};
        acc_n    = r_q.acc;
        wrap_n   = r_q.wrap;
        finish   = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.acc   = '0;
                    r_d.wrap  = 1'b0;
                    r_d.gcnt  = gate_len - GW'(1);
                    r_d.nom   = nom_count;
                    r_d.on_if = (src_sel == SRC_IF) && !recip;
                    r_d.st    = recip ? ST_ARM : ST_GATE;
                end
            end
            ST_GATE: begin
                if (rise) begin
                    acc_n  = acc_inc[CW-1:0];
                    wrap_n = r_q.wrap | acc_inc[CW];
                end
                r_d.acc  = acc_n;
                r_d.wrap = wrap_n;
                r_d.gcnt = r_q.gcnt - GW'(1);
                finish   = (r_q.gcnt == '0);
            end
            ST_ARM: begin
                if (rise) begin
                    r_d.acc = {{(CW-1){1'b0}}, 1'b1};
                    r_d.st  = ST_MEAS;
                end
            end
            default: begin
                if (rise) begin
                    finish = 1'b1;
                end else begin
                    r_d.acc  = acc_inc[CW-1:0];
                    r_d.wrap = r_q.wrap | acc_inc[CW];
                end
            end
        endcase

        if (finish) begin
            r_d.st   = ST_IDLE;
            r_d.done = 1'b1;
            r_d.res  = acc_n;
            r_d.ovf  = wrap_n;
            r_d.ifv  = r_q.on_if;
            r_d.err  = r_q.on_if ? ({1'b0, acc_n} - {1'b0, r_q.nom}) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign count    = r_q.res;
    assign overflow = r_q.ovf;
    assign if_valid = r_q.ifv;
    assign if_error = r_q.err;

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
    parameter int CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] count,
    input logic          overflow,
    input logic          if_valid,
    input logic [CW:0]   if_error
);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || ($stable(count) && $stable(if_error))));

    p_ovf_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> done);

    p_ifv_at_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(if_valid) |-> done);

endmodule

bind freq_meter fm_checker #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .count    (count),
    .overflow (overflow),
    .if_valid (if_valid),
    .if_error (if_error)
);

// File: tb/sim_freq_meter.sv
module sim_freq_meter;

    localparam int REF_HZ = 1000;
    localparam int IF_NOM = 200;
    localparam int CW     = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic recip = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] gate_sel = 2'd0;
    logic sig_ext = 1'b0, sig_tone = 1'b0, sig_if = 1'b0;
    logic busy, done, overflow, if_valid;
    logic [CW-1:0] count;
    logic [CW:0] if_error;

    int n_checks = 0;
    int n_fail = 0;
    int per_ext = 8, per_tone = 20, per_if = 5;
    int ph_ext = 0, ph_tone = 0, ph_if = 0;

    always #4 clk = ~clk;

    freq_meter #(.REF_HZ(REF_HZ), .IF_NOM_HZ(IF_NOM), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .recip(recip),
        .src_sel(src_sel), .gate_sel(gate_sel),
        .sig_ext(sig_ext), .sig_tone(sig_tone), .sig_if(sig_if),
        .busy(busy), .done(done), .count(count), .overflow(overflow),
        .if_valid(if_valid), .if_error(if_error)
    );

    // Square waves, updated away from the active edge.
    always @(negedge clk) begin
        ph_ext  = (ph_ext + 1) % per_ext;
        ph_tone = (ph_tone + 1) % per_tone;
        ph_if   = (ph_if + 1) % per_if;
        sig_ext  <= (ph_ext  < per_ext / 2);
        sig_tone <= (ph_tone < per_tone / 2);
        sig_if   <= (ph_if   < per_if / 2);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Runs one measurement; returns 1 if done was seen.
    task automatic measure(input bit rc, input logic [1:0] src, input logic [1:0] g,
                           output bit seen);
        recip = rc; src_sel = src; gate_sel = g;
        repeat (8) @(negedge clk);
        pulse_start();
        seen = 0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    function automatic int gate_cycles(input int g);
        return (g == 0) ? REF_HZ / 100 : (g == 1) ? REF_HZ / 10 : REF_HZ;
    endfunction

    function automatic int nominal(input int g);
        return (g == 0) ? IF_NOM / 100 : (g == 1) ? IF_NOM / 10 : IF_NOM;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        bit seen;
        int lo, hi, held;
        repeat (3) @(negedge clk);
        // R10 reset values
        check(!busy && !done && count == 0 && !overflow && !if_valid && if_error == 0,
              "R10 reset outputs", int'(count), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2: gated sweep over every gate code and several periods
        for (int g = 0; g < 4; g++) begin
            for (int k = 0; k < 3; k++) begin
                per_ext = (k == 0) ? 4 : (k == 1) ? 10 : 3;
                measure(1'b0, 2'd0, 2'(g), seen);
                lo = gate_cycles(g) / per_ext;
                hi = (gate_cycles(g) + per_ext - 1) / per_ext;
                check(seen, "R1 done seen", int'(seen), 1);
                check(int'(count) >= lo && int'(count) <= hi, "R2 gated count", int'(count), lo);
                check(!if_valid && if_error == 0, "R5 no IF flag on ext", int'(if_valid), 0);
                @(negedge clk);
                check(!done, "R7 done single cycle", int'(done), 0);
            end
        end

        // R3: period sweep on the tone source
        for (int p = 3; p <= 40; p++) begin
            per_tone = p;
            measure(1'b1, 2'd1, 2'd0, seen);
            check(seen && int'(count) == p, "R3 period count", int'(count), p);
            check(!overflow, "R6 no overflow", int'(overflow), 0);
        end

        // R4: source select picks the right input
        per_ext = 8; per_tone = 20; per_if = 5;
        for (int s = 0; s < 4; s++) begin
            measure(1'b1, 2'(s), 2'd0, seen);
            lo = (s == 1) ? 20 : (s == 2) ? 5 : 8;
            check(int'(count) == lo, "R4 source select", int'(count), lo);
            check(!if_valid, "R5 no IF flag in period mode", int'(if_valid), 0);
        end

        // R5: IF offset, sweep periods around nominal
        for (int g = 0; g < 3; g++) begin
            for (int k = 0; k < 3; k++) begin
                per_if = (k == 0) ? 5 : (k == 1) ? 4 : 10;
                measure(1'b0, 2'd2, 2'(g), seen);
                check(if_valid, "R5 IF valid", int'(if_valid), 1);
                check($signed(if_error) == int'(count) - nominal(g), "R5 IF offset",
                      int'($signed(if_error)), int'(count) - nominal(g));
                lo = gate_cycles(g) / per_if;
                hi = (gate_cycles(g) + per_if - 1) / per_if;
                check(int'(count) >= lo && int'(count) <= hi, "R1 IF count", int'(count), lo);
            end
        end
        per_if = 4;
        measure(1'b0, 2'd2, 2'd2, seen);
        check($signed(if_error) > 0, "R5 fast IF positive", int'($signed(if_error)), 50);
        per_if = 10;
        measure(1'b0, 2'd2, 2'd2, seen);
        check($signed(if_error) < 0, "R5 slow IF negative", int'($signed(if_error)), -100);

        // R6: overflow on a long period, then cleared
        per_tone = 1100;
        repeat (2200) @(negedge clk);
        measure(1'b1, 2'd1, 2'd0, seen);
        check(seen && overflow, "R6 overflow set", int'(overflow), 1);
        check(int'(count) == 1100 - 1024, "R6 wrapped count", int'(count), 76);
        per_tone = 12;
        measure(1'b1, 2'd1, 2'd0, seen);
        check(!overflow && count == 12, "R6 overflow cleared", int'(overflow), 0);

        // R8: result held after done and through a later start
        held = int'(count);
        repeat (20) @(negedge clk);
        check(int'(count) == held && !done, "R8 hold idle", int'(count), held);
        per_tone = 300;
        repeat (600) @(negedge clk);
        recip = 1'b1; src_sel = 2'd1;
        pulse_start();
        repeat (5) @(negedge clk);
        check(busy, "R7 busy after start", int'(busy), 1);
        check(int'(count) == held, "R8 hold through start", int'(count), held);

        // R9: second start while busy is ignored
        repeat (20) @(negedge clk);
        pulse_start();
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check(seen && count == 300, "R9 start while busy ignored", int'(count), 300);
        lo = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (done || busy) lo++;
        end
        check(lo == 0, "R9 no extra measurement", lo, 0);

        finish_run();
    end

endmodule